// File: doc/BRIEF.md
# Single-Player Ball-and-Paddle Game Engine

This block renders one frame after another of a one-player bat-and-ball game on a 640x480 raster. It does not generate sync. A separate timing generator gives it the current beam column and row, a flag that says the beam is in the visible area, and a one-cycle pixel strobe. For each pixel the block decides whether that pixel belongs to the ball, the paddle or the frame border. It then drives single-bit red, green and blue outputs from a palette chosen by two switch inputs.

A paddle sits near the bottom of the screen. Its horizontal position comes from an externally decoded rotary-encoder count. A mode switch can instead make the paddle follow the ball by itself. While the picture is scanned, four edge probes on the ball look for contact with the border or the paddle. A hit is latched as a sticky flag, and the flags drive status LEDs. On the first line after the visible area, the ball turns around on each axis where a hit was flagged and steps one pixel on both axes. The flags are then cleared for the next frame.

Top module: `pong_engine`

## Requirements
- R1: After synchronous active-low reset, the ball's top-left corner is at column 312, row 232. The ball moves right and down, and all four hit flags are zero.
- R2: While `in_disp` is low, `red`, `green` and `blue` are all 0, whatever the beam position.
- R3: Object priority is ball over paddle over border, and the background is black. The colour bits are {red,green,blue}. Palette 0 draws every object as 111. Palette 1 draws ball 100, paddle 110 and border 111. Palette 2 draws ball 110, paddle 100 and border 001. Palette 3 draws ball 010, paddle 011 and border 101.
- R4: The ball is a 16x16 square. The border is every pixel with column < 8, column >= 632, row < 8 or row >= 472. The paddle is 80 pixels wide and covers rows 460 to 467.
- R5: With `auto_pad` low, the paddle's left column equals `enc_pos`, clamped to at most 560.
- R6: With `auto_pad` high, the paddle's left column is the ball's column minus 32, clamped to the range 0 to 560.
- R7: Probe pixels are taken relative to the ball corner (bx,by). The left probe is (bx, by+8), the right probe is (bx+15, by+8), the top probe is (bx+8, by) and the bottom probe is (bx+8, by+15). When the beam is on a probe pixel that is also border or paddle, that probe's flag is set. The flag bits in `hit_flags` are bit 0 left, bit 1 right, bit 2 top, bit 3 bottom.
- R8: A flag is set only in a cycle where `pix_en` and `in_disp` are both high. Once set, it stays set until the frame update.
- R9: The frame update happens on a `pix_en` cycle with beam column 0 and row 480. A left hit makes the ball move right, a right hit makes it move left, a top hit makes it move down and a bottom hit makes it move up. The ball then moves one pixel on each axis in its new direction. All flags read zero after the update.
- R10: The ball does not move on any cycle other than a frame update: not when `pix_en` is low, and not at any other beam position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | One-cycle strobe that marks a pixel |
| in_disp | input | 1 | Beam is in the visible area |
| beam_x | input | 10 | Current beam column |
| beam_y | input | 10 | Current beam row |
| enc_pos | input | 10 | Encoder-driven paddle position |
| auto_pad | input | 1 | 1 makes the paddle follow the ball |
| palette | input | 2 | Colour scheme select |
| red | output | 1 | Red colour bit |
| green | output | 1 | Green colour bit |
| blue | output | 1 | Blue colour bit |
| hit_flags | output | 4 | Latched hits: left, right, top, bottom |

## Verification
The hardest state to reach is a real collision. A hit depends on the ball's position, which only changes by one pixel per frame. Scanning full frames to get there would cost hundreds of thousands of cycles. The bench therefore drives the beam straight to the four probe pixels of a model ball, then to the update position. Each frame then costs about twenty cycles, so a thousand frames carry the ball into all four borders and onto the self-steering paddle. At every one of those probe visits, a copy of the probes is first presented with the strobe or the visible flag low, to show that the gating works.

// File: rtl/pong_pkg.sv
// Shared types for the game engine: the hit-flag layout, the colour triple
// and the palette lookup. Assumes single-bit colour channels.
package pong_pkg;

    // Bit 0 left, bit 1 right, bit 2 top, bit 3 bottom.
    typedef struct packed {
        logic bot;
        logic top;
        logic rgt;
        logic lft;
    } hit_t;

    typedef struct packed {
        logic r;
        logic g;
        logic b;
    } rgb_t;

    typedef enum logic [1:0] {
        OBJ_BALL = 2'd0,
        OBJ_PAD  = 2'd1,
        OBJ_BRD  = 2'd2
    } obj_e;

    // Colour of one object under one palette setting.
    function automatic rgb_t obj_color(input logic [1:0] pal, input obj_e obj);
        rgb_t c;
        c = '{r: 1'b1, g: 1'b1, b: 1'b1};
        case (pal)
            2'd1: case (obj)
                OBJ_BALL: c = '{r: 1'b1, g: 1'b0, b: 1'b0};
                OBJ_PAD:  c = '{r: 1'b1, g: 1'b1, b: 1'b0};
                default:  c = '{r: 1'b1, g: 1'b1, b: 1'b1};
            endcase
            2'd2: case (obj)
                OBJ_BALL: c = '{r: 1'b1, g: 1'b1, b: 1'b0};
                OBJ_PAD:  c = '{r: 1'b1, g: 1'b0, b: 1'b0};
                default:  c = '{r: 1'b0, g: 1'b0, b: 1'b1};
            endcase
            2'd3: case (obj)
                OBJ_BALL: c = '{r: 1'b0, g: 1'b1, b: 1'b0};
                OBJ_PAD:  c = '{r: 1'b0, g: 1'b1, b: 1'b1};
                default:  c = '{r: 1'b1, g: 1'b0, b: 1'b1};
            endcase
            default: c = '{r: 1'b1, g: 1'b1, b: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pong_paddle.sv
// Paddle placement: picks the encoder value or a position centred on the ball,
// then clamps it so the whole paddle stays inside the active width.
// Assumes PAD_W >= BALL and PAD_W < H_ACT.
module pong_paddle #(
    parameter int H_ACT = 640,
    parameter int PAD_W = 80,
    parameter int BALL  = 16,
    parameter int XW    = 10
) (
    input  logic          auto_pad,
    input  logic [XW-1:0] enc_pos,
    input  logic [XW-1:0] ball_x,
    output logic [XW-1:0] pad_x
);
    localparam logic [XW-1:0] MAXX = XW'(H_ACT - PAD_W);
    localparam logic [XW-1:0] OFFS = XW'(PAD_W / 2 - BALL / 2);

    logic [XW-1:0] want;

    // Select the requested position and clamp it to the right limit.
    always_comb begin
        if (auto_pad) begin
            want = (ball_x < OFFS) ? '0 : ball_x - OFFS;
        end else begin
            want = enc_pos;
        end
        pad_x = (want > MAXX) ? MAXX : want;
    end
endmodule

// File: rtl/pong_shapes.sv
// Pixel classification: says whether the current beam position lies on the
// ball, on the paddle or on the frame border. Purely combinational.
// Assumes coordinates plus object sizes fit in XW+1 bits.
module pong_shapes #(
    parameter int H_ACT = 640,
    parameter int V_ACT = 480,
    parameter int BRD   = 8,
    parameter int BALL  = 16,
    parameter int PAD_W = 80,
    parameter int PAD_H = 8,
    parameter int PAD_Y = 460,
    parameter int XW    = 10
) (
    input  logic [XW-1:0] beam_x,
    input  logic [XW-1:0] beam_y,
    input  logic [XW-1:0] ball_x,
    input  logic [XW-1:0] ball_y,
    input  logic [XW-1:0] pad_x,
    output logic          on_ball,
    output logic          on_pad,
    output logic          on_brd
);
    localparam int CW = XW + 1;

    logic [CW-1:0] ex, ey, bx, by, px;

    assign ex = CW'(beam_x);
    assign ey = CW'(beam_y);
    assign bx = CW'(ball_x);
    assign by = CW'(ball_y);
    assign px = CW'(pad_x);

    // Range tests for the three drawn objects.
    always_comb begin
        on_ball = (ex >= bx) && (ex < bx + CW'(BALL)) &&
                  (ey >= by) && (ey < by + CW'(BALL));
        on_pad  = (ex >= px) && (ex < px + CW'(PAD_W)) &&
                  (ey >= CW'(PAD_Y)) && (ey < CW'(PAD_Y + PAD_H));
        on_brd  = (ex < CW'(BRD)) || (ex >= CW'(H_ACT - BRD)) ||
                  (ey < CW'(BRD)) || (ey >= CW'(V_ACT - BRD));
    end
endmodule

// File: rtl/pong_hits.sv
// Collision collector: four probe pixels on the ball's edges. A probe that
// meets an obstacle pixel during a visible pixel strobe sets a sticky flag.
// All flags clear on the frame update strobe. Assumes BALL is even.
module pong_hits
    import pong_pkg::*;
#(
    parameter int BALL = 16,
    parameter int XW   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          in_disp,
    input  logic          tick,
    input  logic          obst,
    input  logic [XW-1:0] beam_x,
    input  logic [XW-1:0] beam_y,
    input  logic [XW-1:0] ball_x,
    input  logic [XW-1:0] ball_y,
    output hit_t          hits
);
    localparam logic [XW-1:0] HALF = XW'(BALL / 2);
    localparam logic [XW-1:0] LAST = XW'(BALL - 1);

    logic [XW-1:0] mid_x, mid_y, far_x, far_y;
    hit_t          probe;

    assign mid_x = ball_x + HALF;
    assign mid_y = ball_y + HALF;
    assign far_x = ball_x + LAST;
    assign far_y = ball_y + LAST;

    // Which edge probe, if any, the beam sits on.
    always_comb begin
        probe.lft = (beam_x == ball_x) && (beam_y == mid_y);
        probe.rgt = (beam_x == far_x)  && (beam_y == mid_y);
        probe.top = (beam_x == mid_x)  && (beam_y == ball_y);
        probe.bot = (beam_x == mid_x)  && (beam_y == far_y);
    end

    // Sticky flags: set on contact, cleared by the frame update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hits <= '0;
        end else if (tick) begin
            hits <= '0;
        end else if (pix_en && in_disp && obst) begin
            hits <= hit_t'(hits | probe);
        end
    end
endmodule

// File: rtl/pong_ball.sv
// Ball motion: once per frame, reverses direction on each flagged side and
// steps one pixel on each axis. Resets to mid-screen heading right and down.
// Assumes the border keeps the ball away from the coordinate wrap.
module pong_ball
    import pong_pkg::*;
#(
    parameter int H_ACT = 640,
    parameter int V_ACT = 480,
    parameter int BALL  = 16,
    parameter int XW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  hit_t          hits,
    output logic [XW-1:0] ball_x,
    output logic [XW-1:0] ball_y
);
    localparam logic [XW-1:0] X0 = XW'((H_ACT - BALL) / 2);
    localparam logic [XW-1:0] Y0 = XW'((V_ACT - BALL) / 2);

    logic go_right, go_down;
    logic nxt_right, nxt_down;

    // Next direction from the flags gathered over the frame.
    always_comb begin
        nxt_right = go_right;
        nxt_down  = go_down;
        if (hits.lft) begin
            nxt_right = 1'b1;
        end else if (hits.rgt) begin
            nxt_right = 1'b0;
        end
        if (hits.top) begin
            nxt_down = 1'b1;
        end else if (hits.bot) begin
            nxt_down = 1'b0;
        end
    end

    // Position and direction registers, advanced on the frame update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ball_x   <= X0;
            ball_y   <= Y0;
            go_right <= 1'b1;
            go_down  <= 1'b1;
        end else if (tick) begin
            go_right <= nxt_right;
            go_down  <= nxt_down;
            ball_x   <= nxt_right ? ball_x + 1'b1 : ball_x - 1'b1;
            ball_y   <= nxt_down  ? ball_y + 1'b1 : ball_y - 1'b1;
        end
    end
endmodule

// File: rtl/pong_engine.sv
// Top of the game engine. Takes beam coordinates from an external timing
// generator and produces 1-bit colour channels plus latched hit flags.
// Assumes beam_y reaches V_ACT at beam_x == 0 once per frame with pix_en high.
module pong_engine
    import pong_pkg::*;
#(
    parameter int H_ACT = 640,
    parameter int V_ACT = 480,
    parameter int BRD   = 8,
    parameter int BALL  = 16,
    parameter int PAD_W = 80,
    parameter int PAD_H = 8,
    parameter int PAD_Y = 460,
    parameter int XW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          in_disp,
    input  logic [XW-1:0] beam_x,
    input  logic [XW-1:0] beam_y,
    input  logic [XW-1:0] enc_pos,
    input  logic          auto_pad,
    input  logic [1:0]    palette,
    output logic          red,
    output logic          green,
    output logic          blue,
    output logic [3:0]    hit_flags
);
    localparam logic [XW-1:0] UPD_ROW = XW'(V_ACT);

    logic [XW-1:0] ball_x, ball_y, pad_x;
    logic          on_ball, on_pad, on_brd;
    logic          tick;
    hit_t          hits;
    rgb_t          pix;

    // Frame update strobe: first pixel of the first line below the picture.
    assign tick = pix_en && (beam_y == UPD_ROW) && (beam_x == '0);

    pong_paddle #(.H_ACT(H_ACT), .PAD_W(PAD_W), .BALL(BALL), .XW(XW)) paddle_i (
        .auto_pad (auto_pad),
        .enc_pos  (enc_pos),
        .ball_x   (ball_x),
        .pad_x    (pad_x)
    );

    pong_shapes #(
        .H_ACT(H_ACT), .V_ACT(V_ACT), .BRD(BRD), .BALL(BALL),
        .PAD_W(PAD_W), .PAD_H(PAD_H), .PAD_Y(PAD_Y), .XW(XW)
    ) shapes_i (
        .beam_x  (beam_x),
        .beam_y  (beam_y),
        .ball_x  (ball_x),
        .ball_y  (ball_y),
        .pad_x   (pad_x),
        .on_ball (on_ball),
        .on_pad  (on_pad),
        .on_brd  (on_brd)
    );

    pong_hits #(.BALL(BALL), .XW(XW)) hits_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_en  (pix_en),
        .in_disp (in_disp),
        .tick    (tick),
        .obst    (on_brd | on_pad),
        .beam_x  (beam_x),
        .beam_y  (beam_y),
        .ball_x  (ball_x),
        .ball_y  (ball_y),
        .hits    (hits)
    );

    pong_ball #(.H_ACT(H_ACT), .V_ACT(V_ACT), .BALL(BALL), .XW(XW)) ball_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .hits   (hits),
        .ball_x (ball_x),
        .ball_y (ball_y)
    );

    // Colour pick by object priority, blanked outside the picture.
    always_comb begin
        pix = '0;
        if (in_disp) begin
            if (on_ball) begin
                pix = obj_color(palette, OBJ_BALL);
            end else if (on_pad) begin
                pix = obj_color(palette, OBJ_PAD);
            end else if (on_brd) begin
                pix = obj_color(palette, OBJ_BRD);
            end
        end
    end

    assign red       = pix.r;
    assign green     = pix.g;
    assign blue      = pix.b;
    assign hit_flags = hits;
endmodule

// File: rtl/pong_engine_chk.sv
// Property checker for the game engine, attached to the top through bind.
// Observes ports plus the ball and paddle registers of the top scope.
module pong_engine_chk #(
    parameter int H_ACT = 640,
    parameter int V_ACT = 480,
    parameter int PAD_W = 80,
    parameter int XW    = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_en,
    input logic          in_disp,
    input logic [XW-1:0] beam_x,
    input logic [XW-1:0] beam_y,
    input logic          red,
    input logic          green,
    input logic          blue,
    input logic [3:0]    hit_flags,
    input logic [XW-1:0] ball_x,
    input logic [XW-1:0] ball_y,
    input logic [XW-1:0] pad_x
);
    logic upd;
    assign upd = pix_en && (beam_y == XW'(V_ACT)) && (beam_x == '0);

    AST_DARK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_disp |-> ({red, green, blue} == 3'b000)); // R2

    AST_PAD_ON_SCREEN: assert property (@(posedge clk) disable iff (!rst_n)
        pad_x <= XW'(H_ACT - PAD_W)); // R5

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ((hit_flags & $past(hit_flags)) == $past(hit_flags))); // R8

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (hit_flags == 4'b0000)); // R9

    AST_BALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> ((ball_x == $past(ball_x) + 1'b1) || (ball_x == $past(ball_x) - 1'b1))
                && ((ball_y == $past(ball_y) + 1'b1) || (ball_y == $past(ball_y) - 1'b1))); // R9

    AST_BALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(ball_x) && $stable(ball_y))); // R10
endmodule

bind pong_engine pong_engine_chk #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .PAD_W(PAD_W), .XW(XW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_en    (pix_en),
    .in_disp   (in_disp),
    .beam_x    (beam_x),
    .beam_y    (beam_y),
    .red       (red),
    .green     (green),
    .blue      (blue),
    .hit_flags (hit_flags),
    .ball_x    (ball_x),
    .ball_y    (ball_y),
    .pad_x     (pad_x)
);

// File: tb/pong_engine_tb_top.sv
`timescale 1ns/1ps
module pong_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_en = 1'b0;
    logic       in_disp = 1'b0;
    logic [9:0] beam_x = '0;
    logic [9:0] beam_y = '0;
    logic [9:0] enc_pos = 10'd100;
    logic       auto_pad = 1'b0;
    logic [1:0] palette = 2'd1;
    logic       red, green, blue;
    logic [3:0] hit_flags;

    always #2.5 clk = ~clk;

    pong_engine dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .in_disp(in_disp),
        .beam_x(beam_x), .beam_y(beam_y), .enc_pos(enc_pos),
        .auto_pad(auto_pad), .palette(palette),
        .red(red), .green(green), .blue(blue), .hit_flags(hit_flags)
    );

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [9:0] x;
        logic [9:0] y;
        logic       vis;
        logic [1:0] pal;
        logic       aut;
        logic [9:0] enc;
        logic [2:0] exp;
        logic [3:0] req;
    } vec_t;

    // Colour vectors, all taken with the ball at its reset place (312,232).
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{10'd320, 10'd240, 1'b1, 2'd1, 1'b0, 10'd100,  3'b100, 4'd3}, // R3 ball
        '{10'd320, 10'd240, 1'b0, 2'd1, 1'b0, 10'd100,  3'b000, 4'd2}, // R2 blank
        '{10'd100, 10'd462, 1'b1, 2'd1, 1'b0, 10'd100,  3'b110, 4'd5}, // R5 left edge
        '{10'd179, 10'd462, 1'b1, 2'd1, 1'b0, 10'd100,  3'b110, 4'd5}, // R5 right edge
        '{10'd180, 10'd462, 1'b1, 2'd1, 1'b0, 10'd100,  3'b000, 4'd4}, // R4 width
        '{10'd0,   10'd0,   1'b1, 2'd1, 1'b0, 10'd100,  3'b111, 4'd4}, // R4 corner
        '{10'd639, 10'd300, 1'b1, 2'd2, 1'b0, 10'd100,  3'b001, 4'd3}, // R3 pal2 border
        '{10'd320, 10'd240, 1'b1, 2'd2, 1'b0, 10'd100,  3'b110, 4'd3}, // R3 pal2 ball
        '{10'd150, 10'd467, 1'b1, 2'd3, 1'b0, 10'd100,  3'b011, 4'd3}, // R3 pal3 paddle
        '{10'd150, 10'd468, 1'b1, 2'd3, 1'b0, 10'd100,  3'b000, 4'd4}, // R4 below paddle
        '{10'd559, 10'd462, 1'b1, 2'd1, 1'b0, 10'd1000, 3'b000, 4'd5}, // R5 clamp gap
        '{10'd560, 10'd462, 1'b1, 2'd1, 1'b0, 10'd1000, 3'b110, 4'd5}, // R5 clamped
        '{10'd639, 10'd462, 1'b1, 2'd1, 1'b0, 10'd1000, 3'b110, 4'd3}, // R3 pad over border
        '{10'd280, 10'd462, 1'b1, 2'd1, 1'b1, 10'd100,  3'b110, 4'd6}, // R6 auto left
        '{10'd279, 10'd462, 1'b1, 2'd1, 1'b1, 10'd100,  3'b000, 4'd6}, // R6 auto gap
        '{10'd360, 10'd462, 1'b1, 2'd1, 1'b1, 10'd100,  3'b000, 4'd6}, // R6 auto right
        '{10'd311, 10'd240, 1'b1, 2'd0, 1'b0, 10'd100,  3'b000, 4'd4}, // R4 ball left
        '{10'd327, 10'd247, 1'b1, 2'd0, 1'b0, 10'd100,  3'b111, 4'd4}, // R4 ball corner
        '{10'd328, 10'd247, 1'b1, 2'd0, 1'b0, 10'd100,  3'b000, 4'd4}, // R4 ball right
        '{10'd7,   10'd10,  1'b1, 2'd3, 1'b0, 10'd100,  3'b101, 4'd3}  // R3 pal3 border
    };

    // Model state of the ball.
    int  bx, by;
    bit  dr, dd;
    bit [3:0] seen;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input int x, input int y, input bit vis, input bit pe);
        @(negedge clk);
        beam_x  = 10'(x);
        beam_y  = 10'(y);
        in_disp = vis;
        pix_en  = pe;
    endtask

    task automatic look(input int x, input int y, output int c);
        put(x, y, 1'b1, 1'b0);
        #1 c = int'({red, green, blue});
    endtask

    function automatic int pad_model();
        int p;
        if (auto_pad) p = (bx < 32) ? 0 : bx - 32;
        else p = int'(enc_pos);
        return (p > 560) ? 560 : p;
    endfunction

    function automatic bit obst_model(input int x, input int y, input int p);
        return (x < 8) || (x >= 632) || (y < 8) || (y >= 472) ||
               ((x >= p) && (x < p + 80) && (y >= 460) && (y < 468));
    endfunction

    task automatic run_frames(input int n);
        int c;
        for (int f = 0; f < n; f++) begin
            int px [4];
            int py [4];
            int p;
            bit [3:0] ef;
            px[0] = bx;      py[0] = by + 8;
            px[1] = bx + 15; py[1] = by + 8;
            px[2] = bx + 8;  py[2] = by;
            px[3] = bx + 8;  py[3] = by + 15;
            p = pad_model();
            for (int k = 0; k < 4; k++) ef[k] = obst_model(px[k], py[k], p);
            // R8: probes without strobe or outside the picture set nothing.
            for (int k = 0; k < 4; k++) begin
                put(px[k], py[k], 1'b1, 1'b0);
                put(px[k], py[k], 1'b0, 1'b1);
            end
            put(0, 0, 1'b0, 1'b0);
            #1 chk(hit_flags == 4'b0000, "R8 gated probe", int'(hit_flags), 0);
            // R7: real probes.
            for (int k = 0; k < 4; k++) put(px[k], py[k], 1'b1, 1'b1);
            put(0, 0, 1'b0, 1'b0);
            #1 chk(hit_flags == ef, "R7 flags", int'(hit_flags), int'(ef));
            seen = seen | ef;
            // R9: frame update.
            put(0, 480, 1'b0, 1'b1);
            put(0, 0, 1'b0, 1'b0);
            #1 chk(hit_flags == 4'b0000, "R9 flags cleared", int'(hit_flags), 0);
            if (ef[0]) dr = 1'b1; else if (ef[1]) dr = 1'b0;
            if (ef[2]) dd = 1'b1; else if (ef[3]) dd = 1'b0;
            bx = dr ? bx + 1 : bx - 1;
            by = dd ? by + 1 : by - 1;
            look(bx, by, c);
            chk(c == 4, "R9 ball corner", c, 4);
            look(bx - 1, by, c);
            chk(c != 4, "R9 ball left of corner", c, 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bx = 312; by = 232; dr = 1'b1; dd = 1'b1;
    endtask

    task automatic reset_checks();
        int c;
        palette = 2'd1;
        #1 chk(hit_flags == 4'b0000, "R1 flags", int'(hit_flags), 0);
        look(312, 232, c); chk(c == 4, "R1 ball corner", c, 4);
        look(311, 232, c); chk(c == 0, "R1 left of ball", c, 0);
        look(312, 231, c); chk(c == 0, "R1 above ball", c, 0);
    endtask

    initial begin : main
        int c;
        seen = '0;
        do_reset();
        reset_checks();

        // Vector table for colours, geometry and paddle placement.
        for (int i = 0; i < NV; i++) begin
            palette  = VECS[i].pal;
            auto_pad = VECS[i].aut;
            enc_pos  = VECS[i].enc;
            put(int'(VECS[i].x), int'(VECS[i].y), VECS[i].vis, 1'b0);
            #1 c = int'({red, green, blue});
            checks++;
            if (c != int'(VECS[i].exp)) begin
                errs++;
                $display("FAIL R%0d vector %0d: actual=%0d expected=%0d",
                         VECS[i].req, i, c, VECS[i].exp);
            end
        end
        palette = 2'd1; auto_pad = 1'b0; enc_pos = 10'd100;

        // R10: no move without the exact update strobe.
        put(0, 480, 1'b0, 1'b0);
        put(1, 480, 1'b0, 1'b1);
        put(0, 479, 1'b0, 1'b1);
        look(312, 232, c); chk(c == 4, "R10 ball held", c, 4);
        look(313, 233, c); chk(c == 4, "R10 ball held", c, 4);

        // Manual paddle then self-steering paddle across many frames.
        run_frames(230);
        auto_pad = 1'b1;
        run_frames(770);
        chk(seen == 4'b1111, "R7 all sides hit", int'(seen), 15);

        // R1: reset again mid-game.
        auto_pad = 1'b0;
        do_reset();
        reset_checks();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule